// File: doc/BRIEF.md
# Vectored Interrupt Flag Controller

This block gathers interrupt events from seven timer sources and one external pin. Each source has a flag bit. The timer sources also have enable bits in a mask register, and the external source has its own control register. A flag is pending when it is set and its source is enabled. When `gie_i` is high, the highest-priority pending source drives a single request to the CPU, together with that source's fixed vector address.

Software reads and writes the registers over a plain synchronous register bus. Writes take effect at the clock edge; reads are combinational on the address. A flag clears in two ways: software writes a one to it, or the CPU returns an acknowledge pulse that carries the vector of that source. The external pin can be edge- or level-sensitive. In level mode, its request comes from the synchronised pin and it never latches a flag.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: An event pulse on `tmr_evt_i[b]` sets flag bit b of the flag register (address 1) at the next clock edge, whatever the mask holds. Bit positions: 7 timer2 compare, 6 timer2 overflow, 5 timer1 capture, 4 timer1 compare A, 3 timer1 compare B, 2 timer1 overflow, 0 timer0 overflow.
- R3: A write to the flag register clears each bit written as one and leaves each bit written as zero unchanged. Bit 7 of the external control register (address 2) behaves the same way for the external flag.
- R4: An `ack_i` pulse clears only the flag whose vector equals `ack_vec_i`.
- R5: When an event and a clear (write-one or acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R6: `irq_o` is high only when `gie_i` is high and some flag is set with its enable bit set. The enable bits are: mask register (address 0) bits in the R2 layout for the timers, and bit 0 of address 2 for the external source.
- R7: The lowest vector among pending sources is presented on `irq_vec_o`, and `irq_vec_o` is zero when `irq_o` is low. Vectors: external 0x02, timer2 compare 0x06, timer2 overflow 0x08, timer1 capture 0x0A, timer1 compare A 0x0C, timer1 compare B 0x0E, timer1 overflow 0x10, timer0 overflow 0x12.
- R8: In edge mode (address 2 bit 1 = 0), `ext_pin_i` passes through one synchroniser flop. A rising edge then sets the external flag, which reads as address 2 bit 7 two clock edges after the pin rises.
- R9: In level mode (address 2 bit 1 = 1), the external flag stays zero. The external source is pending while it is enabled and the synchronised pin is high.
- R10: Bit 1 of the mask register and bit 1 of the flag register always read zero, and writes to them have no effect. Address 3 reads zero.
- R11: A write to address 0 stores the written byte in the mask register, with bit 1 forced to zero. Address 2 bits 1:0 are likewise read/write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gie_i | input | 1 | Global interrupt enable |
| ext_pin_i | input | 1 | External interrupt pin, asynchronous |
| tmr_evt_i | input | 8 | Timer event pulses, in the flag register layout |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |
| irq_o | output | 1 | Interrupt request to CPU |
| irq_vec_o | output | 8 | Vector address of the granted source |
| ack_i | input | 1 | One-cycle acknowledge from CPU |
| ack_vec_i | input | 8 | Vector being acknowledged |

## Verification
The assertions assume that `ack_vec_i` matters only in a cycle where `ack_i` is high, that `ack_i` is a single-cycle pulse, and that reset is applied before the first checked edge. The stimulus drives every input on the falling clock edge. It raises `ack_i` for exactly one cycle, usually with the vector currently presented and sometimes with an arbitrary one. It toggles the external pin slowly enough that both its edges and its held levels are exercised.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int DW      = 8;
  localparam int VW      = 8;
  localparam int NSRC    = 8;
  localparam int AW      = 2;
  localparam int RSV_BIT = 1;
  localparam int EXT_FLAG_BIT = 7;

  localparam logic [AW-1:0] A_MASK = 2'd0;
  localparam logic [AW-1:0] A_FLAG = 2'd1;
  localparam logic [AW-1:0] A_EXT  = 2'd2;

  // source index is priority order: 0 external, 1..7 timers
  function automatic int src_bit(int idx);
    return (idx <= 6) ? (8 - idx) : 0;
  endfunction

  function automatic logic [VW-1:0] src_vec(int idx);
    return (idx == 0) ? VW'(2) : VW'(4 + 2 * idx);
  endfunction
endpackage

// File: rtl/vic_pin_cond.sv
module vic_pin_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic lvl_o,
  output logic rise_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
    end
  end

  assign lvl_o  = s1_q;
  assign rise_o = s1_q & ~s2_q;

  a_r8_single_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/vic_flag_cell.sv
module vic_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic hold_zero_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          flag_q <= 1'b0;
    else if (hold_zero_i) flag_q <= 1'b0;
    else if (set_i)       flag_q <= 1'b1;
    else if (clr_i)       flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && clr_i && !hold_zero_i) |=> flag_o);
  // R3 and R4: a clear with no competing set empties the flag
  a_r3_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
  a_r9_hold_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_zero_i |=> !flag_o);
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter import vic_pkg::*; #(
  parameter int N = NSRC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  pend_i,
  input  logic          gie_i,
  output logic          irq_o,
  output logic [VW-1:0] vec_o,
  output logic [N-1:0]  grant_o
);
  always_comb begin
    grant_o = '0;
    vec_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        vec_o      = src_vec(i);
      end
    end
    if (!gie_i) begin
      grant_o = '0;
      vec_o   = '0;
    end
  end

  assign irq_o = |grant_o;

  a_r6_gie_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> !irq_o);
  a_r6_grant_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |(grant_o & pend_i));
  a_r7_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  a_r7_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (((grant_o - N'(1)) & pend_i) == '0));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl import vic_pkg::*; #(
  parameter int DATA_W = DW,
  parameter int VEC_W  = VW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gie_i,
  input  logic              ext_pin_i,
  input  logic [DATA_W-1:0] tmr_evt_i,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  input  logic              ack_i,
  input  logic [VEC_W-1:0]  ack_vec_i
);
  localparam logic [DATA_W-1:0] RSV_MASK = DATA_W'(1) << RSV_BIT;

  logic [DATA_W-1:0] mask_q;
  logic              ext_en_q, ext_lvl_q;
  logic              pin_lvl, pin_rise;
  logic [NSRC-1:0]   flag, pend, grant;
  logic [DATA_W-1:0] tflag_view;
  logic [VW-1:0]     vec_int;
  logic              unused_rsv;

  assign unused_rsv = tmr_evt_i[RSV_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q    <= '0;
      ext_en_q  <= 1'b0;
      ext_lvl_q <= 1'b0;
    end else if (reg_we_i) begin
      if (reg_addr_i == A_MASK) mask_q <= reg_wdata_i & ~RSV_MASK;
      if (reg_addr_i == A_EXT) begin
        ext_en_q  <= reg_wdata_i[0];
        ext_lvl_q <= reg_wdata_i[1];
      end
    end
  end

  vic_pin_cond u_pin (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (ext_pin_i),
    .lvl_o (pin_lvl),
    .rise_o(pin_rise)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic set_s, w1c_s, ack_s, hold_s;
    assign ack_s = ack_i && (ack_vec_i == VEC_W'(src_vec(g)));
    if (g == 0) begin : g_ext
      assign set_s   = pin_rise;
      assign w1c_s   = reg_we_i && (reg_addr_i == A_EXT) && reg_wdata_i[EXT_FLAG_BIT];
      assign hold_s  = ext_lvl_q;
      assign pend[g] = ext_en_q & (ext_lvl_q ? pin_lvl : flag[g]);
    end else begin : g_tmr
      assign set_s   = tmr_evt_i[src_bit(g)];
      assign w1c_s   = reg_we_i && (reg_addr_i == A_FLAG) && reg_wdata_i[src_bit(g)];
      assign hold_s  = 1'b0;
      assign pend[g] = mask_q[src_bit(g)] & flag[g];
    end

    vic_flag_cell u_flag (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_i      (set_s),
      .clr_i      (w1c_s | ack_s),
      .hold_zero_i(hold_s),
      .flag_o     (flag[g])
    );
  end

  always_comb begin
    tflag_view = '0;
    for (int i = 1; i < NSRC; i++) tflag_view[src_bit(i)] = flag[i];
  end

  always_comb begin
    unique case (reg_addr_i)
      A_MASK:  reg_rdata_o = mask_q;
      A_FLAG:  reg_rdata_o = tflag_view;
      A_EXT: begin
        reg_rdata_o = '0;
        reg_rdata_o[EXT_FLAG_BIT] = flag[0];
        reg_rdata_o[1] = ext_lvl_q;
        reg_rdata_o[0] = ext_en_q;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  vic_arbiter #(.N(NSRC)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend),
    .gie_i  (gie_i),
    .irq_o  (irq_o),
    .vec_o  (vec_int),
    .grant_o(grant)
  );

  assign irq_vec_o = VEC_W'(vec_int);

  a_r10_rsv_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == A_MASK || reg_addr_i == A_FLAG) |-> !reg_rdata_o[RSV_BIT]);
  a_r11_mask_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_MASK) |=> mask_q == ($past(reg_wdata_i) & ~RSV_MASK));
  a_r9_level_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gie_i && ext_en_q && ext_lvl_q && pin_lvl) |-> (irq_o && irq_vec_o == VEC_W'(2)));
endmodule

// File: tb/vec_irq_ctrl_tb.sv
`timescale 1ns/1ps
module vec_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gie = 1'b0, pin = 1'b0;
  logic [7:0] evt = '0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;
  logic [7:0] vec;
  logic       ack = 1'b0;
  logic [7:0] ackv = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  logic [7:0] m_mask = '0;
  logic [7:0] m_flag = '0; // index: 0 ext, 1..7 timers
  logic       m_en = 0, m_lvl = 0, m_s1 = 0, m_s2 = 0;

  always #2 clk = ~clk;

  vec_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .gie_i(gie), .ext_pin_i(pin),
    .tmr_evt_i(evt), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .irq_vec_o(vec),
    .ack_i(ack), .ack_vec_i(ackv)
  );

  function automatic int tbit(int i);
    return (i <= 6) ? 8 - i : 0;
  endfunction

  function automatic logic [7:0] tvec(int i);
    case (i)
      0: return 8'h02; 1: return 8'h06; 2: return 8'h08; 3: return 8'h0A;
      4: return 8'h0C; 5: return 8'h0E; 6: return 8'h10; default: return 8'h12;
    endcase
  endfunction

  function automatic logic [7:0] m_pend();
    logic [7:0] p;
    p[0] = m_en & (m_lvl ? m_s1 : m_flag[0]);
    for (int i = 1; i < 8; i++) p[i] = m_mask[tbit(i)] & m_flag[i];
    return p;
  endfunction

  function automatic logic m_irq();
    return gie && (m_pend() != 0);
  endfunction

  function automatic logic [7:0] m_vec();
    logic [7:0] p;
    p = m_pend();
    if (!gie) return 8'h00;
    for (int i = 0; i < 8; i++) if (p[i]) return tvec(i);
    return 8'h00;
  endfunction

  function automatic logic [7:0] m_rd(logic [1:0] a);
    logic [7:0] r;
    r = '0;
    case (a)
      2'd0: r = m_mask;
      2'd1: for (int i = 1; i < 8; i++) r[tbit(i)] = m_flag[i];
      2'd2: r = {m_flag[0], 5'b0, m_lvl, m_en};
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic m_edge();
    logic [7:0] nf;
    logic rise, st, cl;
    rise = m_s1 & ~m_s2;
    for (int i = 0; i < 8; i++) begin
      st = (i == 0) ? rise : evt[tbit(i)];
      cl = (i == 0) ? (we && addr == 2'd2 && wdata[7]) : (we && addr == 2'd1 && wdata[tbit(i)]);
      cl = cl | (ack && ackv == tvec(i));
      if (i == 0 && m_lvl) nf[i] = 1'b0;
      else if (st)         nf[i] = 1'b1;
      else if (cl)         nf[i] = 1'b0;
      else                 nf[i] = m_flag[i];
    end
    m_flag = nf;
    if (we && addr == 2'd0) m_mask = wdata & 8'hFD;
    if (we && addr == 2'd2) begin m_en = wdata[0]; m_lvl = wdata[1]; end
    m_s2 = m_s1;
    m_s1 = pin;
  endtask

  task automatic step(input logic [7:0] e, input logic w, input logic [1:0] a,
                      input logic [7:0] d, input logic k, input logic [7:0] kv,
                      input string req);
    evt = e; we = w; addr = a; wdata = d; ack = k; ackv = kv;
    @(posedge clk);
    m_edge();
    @(negedge clk);
    evt = '0; we = 1'b0; ack = 1'b0;
    chk("R6 irq", irq, m_irq());
    chk("R7 vector", vec, m_vec());
    chk(req, rdata, m_rd(addr));
  endtask

  task automatic rd(input logic [1:0] a, input string req);
    step('0, 1'b0, a, '0, 1'b0, '0, req);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string req);
    step('0, 1'b1, a, d, 1'b0, '0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq, 0);
    rd(2'd0, "R1"); rd(2'd1, "R1"); rd(2'd2, "R1"); rd(2'd3, "R10");

    // R11 mask write, R10 reserved bit
    wr(2'd0, 8'hA5, "R11");
    rd(2'd0, "R11");
    chk("R11 mask", rdata, 8'hA5);
    wr(2'd0, 8'hFF, "R10");
    rd(2'd0, "R10");
    chk("R10 mask rsv", rdata, 8'hFD);
    wr(2'd0, 8'h00, "R11");

    // R2 event sets flag without mask
    step(8'h20, 1'b0, 2'd1, '0, 1'b0, '0, "R2");
    chk("R2 flag", rdata, 8'h20);
    chk("R6 masked", irq, 0);
    // R10 reserved event and write on flag register
    step(8'h02, 1'b1, 2'd1, 8'h00, 1'b0, '0, "R10");
    rd(2'd1, "R10");
    chk("R10 flag rsv", rdata, 8'h20);

    // R3 write-one-to-clear
    wr(2'd1, 8'hDF, "R3");
    rd(2'd1, "R3");
    chk("R3 zero keeps", rdata, 8'h20);
    wr(2'd1, 8'h20, "R3");
    rd(2'd1, "R3");
    chk("R3 one clears", rdata, 8'h00);

    // R5 set beats clear
    step(8'h10, 1'b0, 2'd1, '0, 1'b0, '0, "R5");
    step(8'h10, 1'b1, 2'd1, 8'h10, 1'b0, '0, "R5");
    chk("R5 write vs set", rdata, 8'h10);
    step(8'h10, 1'b0, 2'd1, '0, 1'b1, 8'h0C, "R5");
    chk("R5 ack vs set", rdata, 8'h10);

    // R4 ack clears only the named source
    step(8'h80, 1'b0, 2'd1, '0, 1'b0, '0, "R4");
    step('0, 1'b0, 2'd1, '0, 1'b1, 8'h06, "R4");
    chk("R4 ack one", rdata, 8'h10);

    // R6/R7 priority between pending sources
    step(8'h04, 1'b1, 2'd0, 8'hFF, 1'b0, '0, "R11");
    gie = 1'b1;
    rd(2'd1, "R7");
    chk("R7 lowest vec", vec, 8'h0C);
    chk("R6 irq on", irq, 1);
    gie = 1'b0;
    rd(2'd1, "R6");
    chk("R6 gie off", irq, 0);
    chk("R7 vec zero", vec, 8'h00);
    wr(2'd1, 8'hFF, "R3");
    gie = 1'b1;

    // R8 edge mode on external pin
    wr(2'd2, 8'h01, "R11");
    pin = 1'b1;
    rd(2'd2, "R8");
    chk("R8 not yet", rdata, 8'h01);
    rd(2'd2, "R8");
    chk("R8 flag", rdata, 8'h81);
    chk("R7 ext vec", vec, 8'h02);
    rd(2'd2, "R8");
    step('0, 1'b0, 2'd2, '0, 1'b1, 8'h02, "R4");
    chk("R4 ext ack", rdata, 8'h01);
    rd(2'd2, "R8");
    chk("R8 no retrigger", rdata, 8'h01);

    // R9 level mode
    wr(2'd2, 8'h03, "R9");
    rd(2'd2, "R9");
    chk("R9 flag held", rdata, 8'h03);
    chk("R9 level req", vec, 8'h02);
    pin = 1'b0;
    rd(2'd2, "R9");
    chk("R9 pin low", irq, 0);
    pin = 1'b1;
    rd(2'd2, "R9");
    rd(2'd2, "R9");
    chk("R9 edge ignored", rdata, 8'h03);
    wr(2'd2, 8'h00, "R11");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] e, d, kv;
      logic w, k;
      logic [1:0] a;
      gie = ($urandom % 8) != 0;
      if (($urandom % 4) == 0) pin = ~pin;
      e = 8'($urandom) & 8'($urandom) & 8'($urandom);
      w = ($urandom % 6) == 0;
      a = 2'($urandom);
      d = 8'($urandom);
      k = 1'b0; kv = '0;
      if (irq && ($urandom % 2) == 0) begin k = 1'b1; kv = vec; end
      else if (($urandom % 16) == 0) begin k = 1'b1; kv = 8'($urandom % 20); end
      step(e, w, a, d, k, kv, (a == 2'd0) ? "R11" : (a == 2'd1) ? "R2" : (a == 2'd2) ? "R8" : "R10");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule